// File: doc/BRIEF.md
# External Memory Bus Controller

This block connects a processor core with a 22-bit internal address to an external bus in the classic 8051 style. The bus has 20 address pins and an 8-bit data port. Program space and data space are separate, and each can hold up to 4 MB. A program fetch selects one of four program-device selects. A data read or a data write selects one of four data-device selects. PSEN gates program reads, RD and WR strobe data transfers, and ALE marks the address phase so that an external latch can capture it.

The bus runs in one of two modes. In multiplexed mode the low address byte and the data share the data port in time, and the dedicated low-address port goes back to general I/O. In demultiplexed mode the low address byte has its own port for the whole cycle, and the data port carries only data. Three 3-bit configuration fields control the pins. The first sets how many of the upper address pins A16..A19 are driven. The second sets how many program selects exist, and the third sets how many data selects exist. The device-select index is taken from the two address bits just above the highest enabled upper address pin. Every pin that is not enabled shows the value of its general I/O latch input.

A cycle is started with a one-cycle `start` pulse while the block is idle. It runs through an address phase, an address-hold phase, `STB_CYCLES` strobe cycles and a tail cycle. Read data is returned together with a one-cycle `done` pulse.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after reset, the pins take these values: `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `dq_oe` is 0, `busy` and `done` are 0, `rdata`, `pin_ahi`, `pin_alo` and `pin_upper` are 0, and every `pin_ce_n`/`pin_pce_n` bit is 1. After reset all three configuration fields are 3'b111.
- R2: The upper-address field selects how many pins are driven. If its top bit is 0, no pin is enabled. Otherwise the count is (low two bits + 1), so 100 gives A16, 101 gives A17..A16, 110 gives A18..A16 and 111 gives A19..A16. `pin_upper[i]` carries address bit 16+i when it is enabled and `io_upper[i]` when it is not.
- R3: The program-select field and the data-select field use the same encoding as R2 and enable select lines 0 upward. A select pin that is not enabled shows its `io_ce`/`io_pce` bit.
- R4: With n upper lines enabled, the select index is address bits [17+n:16+n]. Select line `idx` goes low only if line `idx` is enabled. Otherwise no select line is asserted.
- R5: Program selects are asserted only for a fetch (kind 2'b00). Data selects are asserted only for a data read (2'b01) or a data write (kind bit 1 set). A select stays low from the address phase through the tail cycle.
- R6: An accepted cycle runs 1 ALE cycle, 1 hold cycle, `STB_CYCLES` strobe cycles and 1 tail cycle. `busy` is high for exactly that span. Only one of `psen_n`/`rd_n`/`wr_n` is low, and only during the strobe cycles.
- R7: In multiplexed mode (`demux_mode`=0) the data port drives address bits 7..0 during the ALE and hold cycles, and `pin_alo` shows `io_lo`.
- R8: In demultiplexed mode, `pin_alo` carries address bits 7..0 for the whole cycle and holds them afterwards. The data port drives the write data for the whole of a write cycle and is released for all other cycles.
- R9: In multiplexed mode, a write drives the write data during the strobe and tail cycles. For a read or a fetch the port is released (`dq_oe`=0) after the hold cycle.
- R10: For a fetch or a data read, `dq_in` is captured at the clock edge that ends the last strobe cycle. `done` is then high for one cycle (the tail), and `rdata` holds the captured byte. Writes leave `rdata` unchanged.
- R11: A `start` or a `cfg_we` that arrives while a cycle is in progress has no effect.
- R12: The bus mode is taken from `demux_mode` when the cycle starts. A change during the cycle does not affect that cycle.
- R13: `pin_ahi` carries address bits 15..8 of the most recent accepted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the three configuration fields |
| cfg_upper | input | 3 | Upper-address pin field |
| cfg_pgm | input | 3 | Program-select field |
| cfg_dat | input | 3 | Data-select field |
| demux_mode | input | 1 | 1 = demultiplexed bus, 0 = multiplexed bus |
| start | input | 1 | Start a bus cycle (taken when idle) |
| kind | input | 2 | 00 fetch, 01 data read, 1x data write |
| addr | input | ADDR_W | Internal address |
| wdata | input | DATA_W | Write data |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| io_lo | input | DATA_W | General I/O latch for the low-address port |
| io_upper | input | UP_LINES | General I/O latches for the upper address pins |
| io_ce | input | UP_LINES | General I/O latches for the program-select pins |
| io_pce | input | UP_LINES | General I/O latches for the data-select pins |
| pin_ahi | output | DATA_W | Address bits 15..8 |
| pin_alo | output | DATA_W | Dedicated low-address port |
| pin_upper | output | UP_LINES | Upper address pins |
| pin_ce_n | output | UP_LINES | Program selects, active low |
| pin_pce_n | output | UP_LINES | Data selects, active low |
| dq_out | output | DATA_W | Data port output value |
| dq_oe | output | 1 | Data port output enable |
| dq_in | input | DATA_W | Data port input value |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The assertions assume that the configuration registers reflected on the pins are the ones the block holds after each edge, so the select-line checks mask by those registers and never by the raw `cfg_*` inputs. They also assume that `dq_in` matters only at the edge that ends a strobe. The stimulus changes inputs only at falling edges. It drives `start`, `cfg_we` and `demux_mode` in the middle of cycles on purpose so that R11 and R12 are exercised, and it randomises the general I/O latches on every cycle so that any pin wrongly falling back to I/O shows up. The field codes with the top bit clear are treated as legal inputs meaning "none", so the stimulus includes them.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  localparam int FIELD_W = 3;

  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_DREAD = 2'b01;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_HOLD = 3'd2,
    PH_STRB = 3'd3,
    PH_TAIL = 3'd4
  } phase_t;

  // Number of enabled lines for a configuration field code.
  function automatic logic [FIELD_W-1:0] field_count(input logic [FIELD_W-1:0] code);
    return code[FIELD_W-1] ? ({1'b0, code[FIELD_W-2:0]} + 3'd1) : 3'd0;
  endfunction

endpackage

// File: rtl/xmem_field_decode.sv
module xmem_field_decode
  import xmem_pkg::*;
#(
  parameter int LINES = 4
) (
  input  logic [FIELD_W-1:0] code,
  output logic [LINES-1:0]   mask
);

  logic [FIELD_W-1:0] count;

  assign count = field_count(code);

  for (genvar i = 0; i < LINES; i++) begin : g_mask
    assign mask[i] = (FIELD_W'(i) < count);
  end

endmodule

// File: rtl/xmem_select.sv
module xmem_select #(
  parameter int ADDR_W = 22,
  parameter int BASE   = 16,
  parameter int LINES  = 4,
  parameter int CNT_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  ucount,
  input  logic [LINES-1:0]  pmask,
  input  logic [LINES-1:0]  dmask,
  input  logic              active,
  input  logic              fetch,
  output logic [LINES-1:0]  psel,
  output logic [LINES-1:0]  dsel
);

  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  logic [ADDR_W-1:0] shifted;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    shifted = addr >> (BASE + int'(ucount));
    idx     = shifted[IDX_W-1:0];
  end

  for (genvar i = 0; i < LINES; i++) begin : g_sel
    assign psel[i] = active &&  fetch && pmask[i] && (idx == IDX_W'(i));
    assign dsel[i] = active && !fetch && dmask[i] && (idx == IDX_W'(i));
  end

endmodule

// File: rtl/xmem_cycle_fsm.sv
module xmem_cycle_fsm
  import xmem_pkg::*;
#(
  parameter int STB_CYCLES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_t phase_q,
  output phase_t phase_nxt,
  output logic   accept,
  output logic   strobe_last
);

  localparam int CW = (STB_CYCLES > 1) ? $clog2(STB_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STB_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign strobe_last = (phase_q == PH_STRB) && (cnt_q == LAST);

  always_comb begin
    phase_nxt = phase_q;
    accept    = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        phase_nxt = PH_ADDR;
        accept    = 1'b1;
      end
      PH_ADDR: phase_nxt = PH_HOLD;
      PH_HOLD: phase_nxt = PH_STRB;
      PH_STRB: if (strobe_last) phase_nxt = PH_TAIL;
      PH_TAIL: phase_nxt = PH_IDLE;
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_nxt;
      cnt_q   <= (phase_q == PH_STRB && !strobe_last) ? cnt_q + 1'b1 : '0;
    end
  end

endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 8,
  parameter int UP_LINES   = 4,
  parameter int STB_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_upper,
  input  logic [2:0]          cfg_pgm,
  input  logic [2:0]          cfg_dat,
  input  logic                demux_mode,
  input  logic                start,
  input  logic [1:0]          kind,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   rdata,
  input  logic [DATA_W-1:0]   io_lo,
  input  logic [UP_LINES-1:0] io_upper,
  input  logic [UP_LINES-1:0] io_ce,
  input  logic [UP_LINES-1:0] io_pce,
  output logic [DATA_W-1:0]   pin_ahi,
  output logic [DATA_W-1:0]   pin_alo,
  output logic [UP_LINES-1:0] pin_upper,
  output logic [UP_LINES-1:0] pin_ce_n,
  output logic [UP_LINES-1:0] pin_pce_n,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe,
  input  logic [DATA_W-1:0]   dq_in,
  output logic                ale,
  output logic                psen_n,
  output logic                rd_n,
  output logic                wr_n
);

  localparam int HI_BASE = 2 * DATA_W;
  localparam logic [FIELD_W-1:0] CFG_RESET = 3'b111;

  // Sequencer
  phase_t phase_q, phase_nxt;
  logic   accept, strobe_last;

  xmem_cycle_fsm #(.STB_CYCLES(STB_CYCLES)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .phase_q    (phase_q),
    .phase_nxt  (phase_nxt),
    .accept     (accept),
    .strobe_last(strobe_last)
  );

  // Configuration and request registers, with their next values
  logic [FIELD_W-1:0] cfg_u_q, cfg_p_q, cfg_d_q;
  logic [FIELD_W-1:0] cfg_u_n, cfg_p_n, cfg_d_n;
  logic               cfg_take;
  logic [1:0]         kind_q, kind_n;
  logic [ADDR_W-1:0]  addr_q, addr_n;
  logic [DATA_W-1:0]  wdata_q, wdata_n;
  logic               demux_q, demux_n;

  assign cfg_take = cfg_we && (phase_q == PH_IDLE);
  assign cfg_u_n  = cfg_take ? cfg_upper : cfg_u_q;
  assign cfg_p_n  = cfg_take ? cfg_pgm   : cfg_p_q;
  assign cfg_d_n  = cfg_take ? cfg_dat   : cfg_d_q;
  assign kind_n   = accept ? kind       : kind_q;
  assign addr_n   = accept ? addr       : addr_q;
  assign wdata_n  = accept ? wdata      : wdata_q;
  assign demux_n  = accept ? demux_mode : demux_q;

  // Field decode
  logic [UP_LINES-1:0] umask, pmask, dmask;
  logic [FIELD_W-1:0]  ucount;

  xmem_field_decode #(.LINES(UP_LINES)) u_dec_up  (.code(cfg_u_n), .mask(umask));
  xmem_field_decode #(.LINES(UP_LINES)) u_dec_pgm (.code(cfg_p_n), .mask(pmask));
  xmem_field_decode #(.LINES(UP_LINES)) u_dec_dat (.code(cfg_d_n), .mask(dmask));

  assign ucount = FIELD_W'($countones(umask));

  // Phase qualifiers for the next cycle
  logic active_n, fetch_n, write_n, strb_n, aphase_n, dphase_n;

  assign active_n = (phase_nxt != PH_IDLE);
  assign fetch_n  = (kind_n == KIND_FETCH);
  assign write_n  = kind_n[1];
  assign strb_n   = (phase_nxt == PH_STRB);
  assign aphase_n = (phase_nxt == PH_ADDR) || (phase_nxt == PH_HOLD);
  assign dphase_n = strb_n || (phase_nxt == PH_TAIL);

  // Device selects
  logic [UP_LINES-1:0] psel, dsel;

  xmem_select #(
    .ADDR_W(ADDR_W),
    .BASE  (HI_BASE),
    .LINES (UP_LINES),
    .CNT_W (FIELD_W)
  ) u_sel (
    .addr  (addr_n),
    .ucount(ucount),
    .pmask (pmask),
    .dmask (dmask),
    .active(active_n),
    .fetch (fetch_n),
    .psel  (psel),
    .dsel  (dsel)
  );

  // Pin values for the next cycle
  logic [UP_LINES-1:0] up_nv, ce_nv, pce_nv;
  logic [DATA_W-1:0]   alo_nv, dq_nv;
  logic                oe_nv;

  for (genvar i = 0; i < UP_LINES; i++) begin : g_pin
    assign up_nv[i]  = umask[i] ? addr_n[HI_BASE + i] : io_upper[i];
    assign ce_nv[i]  = pmask[i] ? !psel[i] : io_ce[i];
    assign pce_nv[i] = dmask[i] ? !dsel[i] : io_pce[i];
  end

  assign alo_nv = demux_n ? addr_n[DATA_W-1:0] : io_lo;

  always_comb begin
    oe_nv = 1'b0;
    dq_nv = '0;
    if (!demux_n) begin
      if (aphase_n) begin
        oe_nv = 1'b1;
        dq_nv = addr_n[DATA_W-1:0];
      end else if (dphase_n && write_n) begin
        oe_nv = 1'b1;
        dq_nv = wdata_n;
      end
    end else if (active_n && write_n) begin
      oe_nv = 1'b1;
      dq_nv = wdata_n;
    end
  end

  // Registered state and outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_u_q   <= CFG_RESET;
      cfg_p_q   <= CFG_RESET;
      cfg_d_q   <= CFG_RESET;
      kind_q    <= KIND_FETCH;
      addr_q    <= '0;
      wdata_q   <= '0;
      demux_q   <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rdata     <= '0;
      pin_ahi   <= '0;
      pin_alo   <= '0;
      pin_upper <= '0;
      pin_ce_n  <= '1;
      pin_pce_n <= '1;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      ale       <= 1'b0;
      psen_n    <= 1'b1;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
    end else begin
      cfg_u_q   <= cfg_u_n;
      cfg_p_q   <= cfg_p_n;
      cfg_d_q   <= cfg_d_n;
      kind_q    <= kind_n;
      addr_q    <= addr_n;
      wdata_q   <= wdata_n;
      demux_q   <= demux_n;
      busy      <= active_n;
      done      <= strobe_last;
      if (strobe_last && !kind_q[1]) rdata <= dq_in;
      pin_ahi   <= addr_n[HI_BASE-1:DATA_W];
      pin_alo   <= alo_nv;
      pin_upper <= up_nv;
      pin_ce_n  <= ce_nv;
      pin_pce_n <= pce_nv;
      dq_out    <= dq_nv;
      dq_oe     <= oe_nv;
      ale       <= (phase_nxt == PH_ADDR);
      psen_n    <= !(strb_n && fetch_n);
      rd_n      <= !(strb_n && (kind_n == KIND_DREAD));
      wr_n      <= !(strb_n && write_n);
    end
  end

endmodule

// File: rtl/xmem_bus_chk.sv
module xmem_bus_chk
  import xmem_pkg::*;
#(
  parameter int LINES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               ale,
  input logic               psen_n,
  input logic               rd_n,
  input logic               wr_n,
  input logic               dq_oe,
  input logic               busy,
  input logic               done,
  input logic [LINES-1:0]   pin_ce_n,
  input logic [LINES-1:0]   pin_pce_n,
  input logic [FIELD_W-1:0] cfg_p_q,
  input logic [FIELD_W-1:0] cfg_d_q
);

  logic [LINES-1:0] pm, dm;

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      pm[i] = FIELD_W'(i) < field_count(cfg_p_q);
      dm[i] = FIELD_W'(i) < field_count(cfg_d_q);
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1); // R6
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    ale |-> (psen_n && rd_n && wr_n)); // R6
  AST_ALE_PULSE: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (psen_n && rd_n && wr_n && !ale)); // R6
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !psen_n) |-> !dq_oe); // R9
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> dq_oe); // R9
  AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~pin_ce_n & pm) && $onehot0(~pin_pce_n & dm)); // R4
  AST_SPACE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !((|(~pin_ce_n & pm)) && (|(~pin_pce_n & dm)))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> busy); // R10

endmodule

bind xmem_bus_ctrl xmem_bus_chk #(.LINES(UP_LINES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ale      (ale),
  .psen_n   (psen_n),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .dq_oe    (dq_oe),
  .busy     (busy),
  .done     (done),
  .pin_ce_n (pin_ce_n),
  .pin_pce_n(pin_pce_n),
  .cfg_p_q  (cfg_p_q),
  .cfg_d_q  (cfg_d_q)
);

// File: tb/xmem_bus_ctrl_test.sv
module xmem_bus_ctrl_test;

  localparam int STB = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_upper = 3'b111, cfg_pgm = 3'b111, cfg_dat = 3'b111;
  logic        demux_mode = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  kind = 2'b00;
  logic [21:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        busy, done;
  logic [7:0]  rdata;
  logic [7:0]  io_lo = '0;
  logic [3:0]  io_upper = '0, io_ce = '0, io_pce = '0;
  logic [7:0]  pin_ahi, pin_alo, dq_out;
  logic [3:0]  pin_upper, pin_ce_n, pin_pce_n;
  logic        dq_oe;
  logic [7:0]  dq_in = '0;
  logic        ale, psen_n, rd_n, wr_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  xmem_bus_ctrl #(.STB_CYCLES(STB)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_upper(cfg_upper), .cfg_pgm(cfg_pgm),
    .cfg_dat(cfg_dat), .demux_mode(demux_mode), .start(start), .kind(kind), .addr(addr),
    .wdata(wdata), .busy(busy), .done(done), .rdata(rdata), .io_lo(io_lo),
    .io_upper(io_upper), .io_ce(io_ce), .io_pce(io_pce), .pin_ahi(pin_ahi),
    .pin_alo(pin_alo), .pin_upper(pin_upper), .pin_ce_n(pin_ce_n), .pin_pce_n(pin_pce_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  function automatic int fcount(input logic [2:0] c);
    return c[2] ? int'(c[1:0]) + 1 : 0;
  endfunction

  // Behavioural reference model, advanced on every rising edge
  bit          started = 0;
  bit          m_rst = 1;
  int          phase = 0;
  logic [2:0]  m_cu = 3'b111, m_cp = 3'b111, m_cd = 3'b111;
  logic [21:0] m_addr = '0;
  int          m_kind = 0;
  logic [7:0]  m_w = '0, m_rdata = '0;
  bit          m_dmx = 0, m_done = 0;
  logic [7:0]  s_lo = '0;
  logic [3:0]  s_up = '0, s_ce = '0, s_pce = '0;

  always @(posedge clk) begin
    started = 1;
    s_lo = io_lo; s_up = io_upper; s_ce = io_ce; s_pce = io_pce;
    if (rst) begin
      m_rst = 1; phase = 0; m_cu = 3'b111; m_cp = 3'b111; m_cd = 3'b111;
      m_addr = '0; m_kind = 0; m_w = '0; m_dmx = 0; m_done = 0; m_rdata = '0;
    end else begin
      m_rst = 0;
      m_done = 0;
      if (phase == 0) begin
        if (cfg_we) begin m_cu = cfg_upper; m_cp = cfg_pgm; m_cd = cfg_dat; end
        if (start) begin
          m_addr = addr; m_kind = int'(kind); m_w = wdata; m_dmx = demux_mode; phase = 1;
        end
      end else if (phase == 2 + STB) begin
        if (m_kind < 2) m_rdata = dq_in;
        m_done = 1;
        phase++;
      end else if (phase == 3 + STB) begin
        phase = 0;
      end else begin
        phase++;
      end
    end
  end

  // Compare every output once per cycle, away from the rising edge
  always @(negedge clk) begin
    if (started) begin
      bit active, strb, tail, wr, e_oe;
      int u, pc, dc, idx;
      logic [7:0] e_dq, e_alo;
      logic [3:0] e_up, e_ce, e_pce;
      string dtag;
      if (m_rst) begin
        chk("R1", "ale", ale, 0);        chk("R1", "psen_n", psen_n, 1);
        chk("R1", "rd_n", rd_n, 1);      chk("R1", "wr_n", wr_n, 1);
        chk("R1", "dq_oe", dq_oe, 0);    chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);      chk("R1", "rdata", rdata, 0);
        chk("R1", "pin_upper", pin_upper, 0);
        chk("R1", "pin_ce_n", pin_ce_n, 4'hF);
        chk("R1", "pin_pce_n", pin_pce_n, 4'hF);
        chk("R1", "pin_alo", pin_alo, 0);
        chk("R1", "pin_ahi", pin_ahi, 0);
      end else begin
        active = (phase != 0);
        strb   = (phase >= 3) && (phase <= 2 + STB);
        tail   = (phase == 3 + STB);
        wr     = (m_kind >= 2);
        dtag   = m_dmx ? "R8" : "R7";
        if (!m_dmx) begin
          e_oe = (phase == 1 || phase == 2) || ((strb || tail) && wr);
          e_dq = (phase == 1 || phase == 2) ? m_addr[7:0] : (e_oe ? m_w : 8'h00);
          e_alo = s_lo;
        end else begin
          e_oe = active && wr;
          e_dq = e_oe ? m_w : 8'h00;
          e_alo = m_addr[7:0];
        end
        u   = fcount(m_cu);
        pc  = fcount(m_cp);
        dc  = fcount(m_cd);
        idx = int'((m_addr >> (16 + u)) & 22'd3);
        for (int i = 0; i < 4; i++) begin
          e_up[i]  = (i < u)  ? m_addr[16 + i] : s_up[i];
          e_ce[i]  = (i < pc) ? !(active && m_kind == 0 && idx == i) : s_ce[i];
          e_pce[i] = (i < dc) ? !(active && m_kind != 0 && idx == i) : s_pce[i];
        end
        chk("R6", "ale", ale, phase == 1);
        chk("R6", "psen_n", psen_n, !(strb && m_kind == 0));
        chk("R6", "rd_n", rd_n, !(strb && m_kind == 1));
        chk("R6", "wr_n", wr_n, !(strb && wr));
        chk("R6", "busy", busy, active);
        chk(dtag, "dq_oe (R9 in write phases)", dq_oe, e_oe);
        chk(dtag, "dq_out", dq_out, e_dq);
        chk(dtag, "pin_alo", pin_alo, e_alo);
        chk("R13", "pin_ahi", pin_ahi, m_addr[15:8]);
        chk("R2", "pin_upper", pin_upper, e_up);
        chk("R3,R4", "pin_ce_n", pin_ce_n, e_ce);
        chk("R5", "pin_pce_n", pin_pce_n, e_pce);
        chk("R10", "done", done, m_done);
        chk("R10", "rdata", rdata, m_rdata);
      end
    end
  end

  // General I/O latches change every cycle
  always @(negedge clk) begin
    io_lo = 8'($urandom); io_upper = 4'($urandom);
    io_ce = 4'($urandom); io_pce = 4'($urandom);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic set_cfg(input logic [2:0] u, input logic [2:0] p, input logic [2:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_upper = u; cfg_pgm = p; cfg_dat = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input logic [1:0] k, input logic [21:0] a, input logic [7:0] w,
                        input logic [7:0] din);
    @(negedge clk);
    kind = k; addr = a; wdata = w; dq_in = din; start = 1;
    @(negedge clk);
    start = 0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    logic [2:0] codes [6] = '{3'b000, 3'b010, 3'b100, 3'b101, 3'b110, 3'b111};
    // R1: reset values are checked by the comparator while rst is high
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: default configuration enables all upper lines and all selects
    // R7, R5, R13: multiplexed fetch, CE2 from address bits 21:20
    access(2'b00, 22'h2ABCDE, 8'h00, 8'h96);
    // R9: multiplexed write, then R10: multiplexed data read
    access(2'b10, 22'h11A5C3, 8'h5A, 8'h00);
    access(2'b01, 22'h3F0F0F, 8'h00, 8'hC3);
    // R8: demultiplexed read, write and fetch
    demux_mode = 1;
    access(2'b01, 22'h012345, 8'h00, 8'h3C);
    access(2'b10, 22'h2FEDCB, 8'hA7, 8'h00);
    access(2'b00, 22'h1C0001, 8'h00, 8'h81);
    // R2, R3, R4: sweep of field codes, including index past the enabled count
    for (int ui = 0; ui < 6; ui++) begin
      for (int ci = 0; ci < 6; ci++) begin
        set_cfg(codes[ui], codes[ci], codes[5 - ci]);
        demux_mode = ci[0];
        access(2'b00, 22'($urandom), 8'h00, 8'($urandom));
        access(2'b01, 22'($urandom), 8'h00, 8'($urandom));
        access(2'b10, 22'h3FFFFF, 8'($urandom), 8'h00);
      end
    end
    // R11: start and configuration writes during a cycle are ignored
    set_cfg(3'b111, 3'b111, 3'b111);
    @(negedge clk);
    kind = 2'b00; addr = 22'h3000AA; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    start = 1; addr = 22'h055555; kind = 2'b10;
    cfg_we = 1; cfg_upper = 3'b000; cfg_pgm = 3'b000; cfg_dat = 3'b000;
    @(negedge clk);
    start = 0; cfg_we = 0;
    while (busy) @(negedge clk);
    access(2'b01, 22'h1ABCDE, 8'h00, 8'h42);
    // R12: mode is taken at start; flip it in the middle of a cycle
    demux_mode = 1;
    @(negedge clk);
    kind = 2'b10; addr = 22'h2468AC; wdata = 8'hE1; start = 1;
    @(negedge clk);
    start = 0; demux_mode = 0;
    while (busy) @(negedge clk);
    access(2'b01, 22'h13579B, 8'h00, 8'h5E);
    // Mixed random traffic
    for (int n = 0; n < 40; n++) begin
      if (n % 5 == 0) set_cfg(codes[$urandom % 6], codes[$urandom % 6], codes[$urandom % 6]);
      demux_mode = 1'($urandom);
      access(2'($urandom % 3), 22'($urandom), 8'($urandom), 8'($urandom));
    end
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule